// File: doc/BRIEF.md
# Scrolling Starfield Generator

This block draws a background of 28 single-pixel stars on a 640×480 raster. It does not keep a table of star positions. It keeps one vertical base coordinate in a register. The horizontal base is a fixed parameter. Every star's position is found from the base by adding constant offsets.

The stars form four phases of seven stars each. Phases are shifted sideways against each other, and the seven stars of a phase each occupy their own vertical band. The pixel walker supplies the current `pix_x` and `pix_y`. The block answers on `star_hit` in the same cycle, with no register between the inputs and the output.

A one-cycle `frame_start` strobe moves the base down by one line. The whole field therefore scrolls as one rigid pattern. Star rows that leave the bottom of the screen reappear at the top.

The scroll logic is a single counter. It has no sequencing states: each clock it either holds or steps.

Top module: `starfield_gen`

## Requirements
- R1: After reset the vertical base is BASE_Y0 (default 0), so with defaults the star of phase 0, index 0 lights pixel (8, 0).
- R2: Star of phase p (0..3) and index k (0..6) sits at column BASE_X + 88·k + 22·p (BASE_X default 8). The x offsets are elaboration-time constants, and no multiplier is used at run time.
- R3: The same star sits at row (base_y + 68·k + 17·p) mod 480, so with base 0 phase 1 index 0 is at (30, 17) and phase 3 index 6 is at (602, 459).
- R4: `star_hit` is 1 only when both `pix_x` and `pix_y` equal a star's coordinates exactly. Stars are one pixel wide, so neighbouring pixels stay dark.
- R5: Each clock edge at which `frame_start` is 1 increases base_y by one. At edges where it is 0, base_y holds.
- R6: base_y wraps from 479 back to 0 on the next strobe.
- R7: Star rows wrap modulo 480. With base_y = 21, the phase 3 index 6 star is on row 0, and with base_y = 479 the phase 0 index 0 star is on row 479.
- R8: At most one star matches any pixel, and no pixel outside 640×480 is ever lit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | One-cycle strobe at the start of each frame, advances the scroll |
| pix_x | input | COORD_W | Current pixel column |
| pix_y | input | COORD_W | Current pixel row |
| star_hit | output | 1 | 1 when the current pixel holds a star (combinational) |

## Verification
The bench builds the block with its default parameters: 640×480 raster, horizontal base 8, initial vertical base 0, pitch 88, phase step 22, band 68, and phase row step 17. These are small enough that 480 single-cycle strobes take the base through a complete lap. That reaches both wrap points: a star row crossing from 479 to 0 when base_y is 21, and the base itself returning from 479 to 0. The default horizontal base keeps the rightmost star at column 602, inside the raster. This lets the bench probe the last star of the last phase as well as the first one.

// File: rtl/starfield_pkg.sv
package starfield_pkg;

    // Column of a star, folded to a constant at elaboration time
    function automatic int star_col(input int base_x, input int pitch,
                                    input int phase_step, input int phase,
                                    input int idx);
        return base_x + pitch * idx + phase_step * phase;
    endfunction

    // Row bias of a star relative to the scrolling base
    function automatic int star_bias(input int band_h, input int phase_row,
                                     input int phase, input int idx);
        return band_h * idx + phase_row * phase;
    endfunction

endpackage

// File: rtl/starfield_scroll.sv
module starfield_scroll #(
    parameter int COORD_W  = 10,
    parameter int V_ACTIVE = 480,
    parameter int BASE_Y0  = 0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_start,
    output logic [COORD_W-1:0] base_y
);
    localparam logic [COORD_W-1:0] LAST_ROW = COORD_W'(V_ACTIVE - 1);
    localparam logic [COORD_W-1:0] RST_ROW  = COORD_W'(BASE_Y0);

    logic [COORD_W-1:0] base_nxt;

    always_comb begin
        base_nxt = base_y;
        if (frame_start) begin
            base_nxt = (base_y == LAST_ROW) ? '0 : base_y + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_y <= RST_ROW;
        end else begin
            base_y <= base_nxt;
        end
    end

    // R5: no strobe, no movement
    a_r5_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(base_y));

    // R5: a strobe moves the base forward by one line
    a_r5_step_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && base_y != LAST_ROW) |=> (base_y == $past(base_y) + 1'b1));

    // R6: the last line wraps to zero
    a_r6_base_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && base_y == LAST_ROW) |=> (base_y == '0));

    // R6: the base never leaves the visible rows
    a_r6_base_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        base_y < COORD_W'(V_ACTIVE));

endmodule

// File: rtl/starfield_star.sv
module starfield_star #(
    parameter int COORD_W  = 10,
    parameter int V_ACTIVE = 480,
    parameter int STAR_X   = 0,
    parameter int STAR_DY  = 0
) (
    input  logic [COORD_W-1:0] base_y,
    input  logic [COORD_W-1:0] pix_x,
    input  logic [COORD_W-1:0] pix_y,
    output logic               hit
);
    localparam int SUM_W = COORD_W + 1;

    logic [SUM_W-1:0]   row_raw;
    logic [COORD_W-1:0] row;

    always_comb begin
        row_raw = {1'b0, base_y} + SUM_W'(STAR_DY);
        if (row_raw >= SUM_W'(V_ACTIVE)) begin
            row = COORD_W'(row_raw - SUM_W'(V_ACTIVE));
        end else begin
            row = row_raw[COORD_W-1:0];
        end
        hit = (pix_x == COORD_W'(STAR_X)) && (pix_y == row);
    end

endmodule

// File: rtl/starfield_gen.sv
module starfield_gen #(
    parameter int COORD_W    = 10,
    parameter int H_ACTIVE   = 640,
    parameter int V_ACTIVE   = 480,
    parameter int PHASES     = 4,
    parameter int PER_PHASE  = 7,
    parameter int BASE_X     = 8,
    parameter int BASE_Y0    = 0,
    parameter int X_PITCH    = 88,
    parameter int PHASE_STEP = 22,
    parameter int BAND_H     = 68,
    parameter int PHASE_ROW  = 17
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_start,
    input  logic [COORD_W-1:0] pix_x,
    input  logic [COORD_W-1:0] pix_y,
    output logic               star_hit
);
    import starfield_pkg::*;

    localparam int NSTARS = PHASES * PER_PHASE;

    logic [COORD_W-1:0] base_y;
    logic [NSTARS-1:0]  hits;

    starfield_scroll #(
        .COORD_W (COORD_W),
        .V_ACTIVE(V_ACTIVE),
        .BASE_Y0 (BASE_Y0)
    ) u_scroll (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_start(frame_start),
        .base_y     (base_y)
    );

    for (genvar p = 0; p < PHASES; p++) begin : g_phase
        for (genvar k = 0; k < PER_PHASE; k++) begin : g_star
            starfield_star #(
                .COORD_W (COORD_W),
                .V_ACTIVE(V_ACTIVE),
                .STAR_X  (star_col(BASE_X, X_PITCH, PHASE_STEP, p, k)),
                .STAR_DY (star_bias(BAND_H, PHASE_ROW, p, k))
            ) u_star (
                .base_y(base_y),
                .pix_x (pix_x),
                .pix_y (pix_y),
                .hit   (hits[p*PER_PHASE+k])
            );
        end
    end

    assign star_hit = |hits;

    // R8: stars never overlap
    a_r8_single_match: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hits));

    // R8: nothing lights outside the raster
    a_r8_inside_raster: assert property (@(posedge clk) disable iff (!rst_n)
        star_hit |-> (pix_x < COORD_W'(H_ACTIVE) && pix_y < COORD_W'(V_ACTIVE)));

endmodule

// File: tb/tb_starfield_gen.sv
module tb_starfield_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_start = 1'b0;
    logic [9:0] pix_x = '0;
    logic [9:0] pix_y = '0;
    logic       star_hit;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    starfield_gen dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_start(frame_start),
        .pix_x      (pix_x),
        .pix_y      (pix_y),
        .star_hit   (star_hit)
    );

    // Base 0 table: column, row, expected hit
    localparam int NV = 10;
    localparam int VX [NV] = '{8,  30, 96, 602, 9, 8, 30, 96, 0, 639};
    localparam int VY [NV] = '{0,  17, 68, 459, 0, 1, 0,  0,  0, 479};
    localparam bit VE [NV] = '{1,  1,  1,  1,   0, 0, 0,  0,  0, 0};

    task automatic probe(input int x, input int y, input bit exp, input string req);
        @(negedge clk);
        pix_x = 10'(x);
        pix_y = 10'(y);
        #1;
        checks++;
        if (star_hit !== exp) begin
            fails++;
            $display("FAIL %s pixel (%0d,%0d): got %b expected %b", req, x, y, star_hit, exp);
        end
    endtask

    task automatic strobe(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            frame_start = 1'b1;
            @(negedge clk);
            frame_start = 1'b0;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset position
        probe(8, 0, 1'b1, "R1");
        // R2 R3 R4 table at base 0
        for (int i = 0; i < NV; i++) begin
            probe(VX[i], VY[i], VE[i], (i < 4) ? "R2/R3" : "R4");
        end
        // R5 one strobe moves one line
        strobe(1);
        probe(8, 1, 1'b1, "R5");
        probe(8, 0, 1'b0, "R5");
        // R5 hold without strobe
        repeat (10) @(negedge clk);
        probe(8, 1, 1'b1, "R5");
        // R7 star row wrap at base 21
        strobe(20);
        probe(602, 0, 1'b1, "R7");
        probe(602, 459, 1'b0, "R7");
        probe(602, 480, 1'b0, "R8");
        // R7 base at last line
        strobe(458);
        probe(8, 479, 1'b1, "R7");
        probe(8, 0, 1'b0, "R7");
        // R6 base wraps to zero
        strobe(1);
        probe(8, 0, 1'b1, "R6");
        probe(602, 459, 1'b1, "R6");
        // R1 reset mid-run returns base to start
        strobe(5);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        probe(8, 0, 1'b1, "R1");
        probe(8, 5, 1'b0, "R1");
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule